// File: doc/BRIEF.md
# Manchester Event Marker Generator

This block drives one debug pin with a short self-clocking marker that names one of sixteen event codes, then holds the pin high to mark a window. Logic elsewhere in the chip pulses a start strobe with a 4-bit code when an event begins. The block first drives a low lead-in chip. It then sends a two-chip preamble whose polarity follows the parity of the code, eight Manchester data chips carrying the code, and a low separator chip. Last, it raises the pin. The pin stays high until a stop strobe arrives. An observer on the pin can recover the chip clock from the transitions and can time the window between the rising edge and the stop.

Every chip lasts `CHIP_CYCLES` clock cycles. Once a marker starts, it runs to the window without interruption. A stop that arrives while the marker is still being sent is remembered and takes effect where the window would open. The pin and the busy flag are both driven from flops, so the pin has no glitches.

Top module: `mnch_marker`

## Requirements
- R1: After reset, pin_o is low and busy_o is low, and no window is open.
- R2: A start is accepted when start_i is high at a clock edge while busy_o is low and no marker is in progress. busy_o then rises, and pin_o goes low for one chip (the lead-in), both from the second clock edge after the accepting edge.
- R3: The two chips after the lead-in form the preamble. For an even code (code bit 0 = 0) it is low then high. For an odd code it is high then low.
- R4: The next eight chips carry the code. Data chip 2i equals the inverse of code bit i and data chip 2i+1 equals code bit i, for i = 0..3, sent from i = 0 up. This is the code with each bit doubled, XORed with 0x55 and sent LSB first (code 0 gives 0x55, code 5 gives 0x66, code 15 gives 0xAA).
- R5: After the data chips, pin_o is low for one separator chip. Then pin_o goes high and busy_o goes low together, 12 chips after the lead-in began.
- R6: Every chip holds pin_o constant for exactly CHIP_CYCLES clock cycles. This applies to the lead-in, preamble, data and separator chips alike.
- R7: start_i is ignored while busy_o is high. A marker in progress keeps its code and its timing.
- R8: While the window is open, pin_o stays high. A stop_i pulse closes the window, and pin_o is low from the second edge after the stop.
- R9: A stop_i pulse during a marker is held pending. At the point where the window would open, pin_o stays low and busy_o falls. The pending stop is then cleared.
- R10: A start accepted while the window is open ends the window. It begins a new marker, with the lead-in driving pin_o low.
- R11: stop_i while no window is open and no marker is running has no effect. The next marker opens its window normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled with code_i |
| code_i | input | CODE_W | Event code to send |
| stop_i | input | 1 | Stop strobe that closes the window |
| pin_o | output | 1 | Marker and window pin |
| busy_o | output | 1 | High while a marker is being sent |

## Verification
Assertions check on every cycle that the chip counter stays within its period and that an accepted start produces a low lead-in with busy set. They also check that the latched code cannot change during a marker, that a stop during a marker is captured and suppresses the window, and that an open window stays high until a stop closes it. The exact chip-by-chip waveform for each of the sixteen codes, including preamble parity, data bit order and chip lengths, is shown only by the bench's sweep. The bench scenarios also cover a start ignored mid-marker, a start that cuts an open window short, and a stop that arrives while idle.

// File: rtl/mnch_pkg.sv
package mnch_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SEND   = 2'd1,
    PH_WINDOW = 2'd2
  } phase_e;

  // lead-in + preamble(2) + data(2*code_w) + separator
  function automatic int unsigned frame_chips(input int unsigned code_w);
    return 2 * code_w + 4;
  endfunction

endpackage

// File: rtl/mnch_chip_timer.sv
module mnch_chip_timer #(
  parameter int unsigned CHIP_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic chip_end_o
);

  localparam int unsigned CNT_W = (CHIP_CYCLES > 1) ? $clog2(CHIP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHIP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign chip_end_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= chip_end_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

endmodule

// File: rtl/mnch_frame_enc.sv
module mnch_frame_enc #(
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned FRAME_CHIPS = 12,
  parameter int unsigned IDX_W       = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              chip_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_CHIPS - 1);

  logic [FRAME_CHIPS-1:0] frame;

  assign frame[0] = 1'b0;            // lead-in
  assign frame[1] = code_i[0];       // even: low then high
  assign frame[2] = ~code_i[0];
  assign frame[FRAME_CHIPS-1] = 1'b0; // separator

  // each code bit doubled, xor 0101..., LSB first
  for (genvar g = 0; g < CODE_W; g++) begin : g_data
    assign frame[3 + 2*g] = ~code_i[g];
    assign frame[4 + 2*g] = code_i[g];
  end

  assign chip_o = (idx_i <= LAST_IDX) ? frame[idx_i] : 1'b0;

endmodule

// File: rtl/mnch_seq.sv
module mnch_seq
  import mnch_pkg::*;
#(
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned FRAME_CHIPS = 12,
  parameter int unsigned IDX_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              stop_i,
  input  logic              chip_end_i,
  output phase_e            phase_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_CHIPS - 1);

  phase_e            phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] code_q;
  logic              pend_q;
  logic              final_chip;

  assign final_chip = chip_end_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      code_q  <= '0;
      pend_q  <= 1'b0;
    end else if (accept_i) begin
      phase_q <= PH_SEND;
      idx_q   <= '0;
      code_q  <= code_i;
      pend_q  <= stop_i;
    end else if (phase_q == PH_SEND) begin
      if (final_chip) begin
        phase_q <= (pend_q || stop_i) ? PH_IDLE : PH_WINDOW;
        pend_q  <= 1'b0;
      end else begin
        if (chip_end_i) idx_q <= idx_q + 1'b1;
        if (stop_i) pend_q <= 1'b1;
      end
    end else if (phase_q == PH_WINDOW && stop_i) begin
      phase_q <= PH_IDLE;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign code_o  = code_q;

  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SEND) |=> $stable(code_q));

  // R9
  stop_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SEND && stop_i && !final_chip && !accept_i) |=> pend_q);

  // R9
  pend_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SEND && final_chip && (pend_q || stop_i)) |=> phase_q == PH_IDLE);

  // R5
  open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SEND && final_chip && !pend_q && !stop_i) |=> phase_q == PH_WINDOW);

endmodule

// File: rtl/mnch_marker.sv
module mnch_marker
  import mnch_pkg::*;
#(
  parameter int unsigned CHIP_CYCLES = 2,
  parameter int unsigned CODE_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              stop_i,
  output logic              pin_o,
  output logic              busy_o
);

  localparam int unsigned FRAME_CHIPS = frame_chips(CODE_W);
  localparam int unsigned IDX_W       = $clog2(FRAME_CHIPS);

  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] code_lat;
  logic              chip_end;
  logic              chip_bit;
  logic              accept;
  logic              pin_q, busy_q;

  // busy_o lags phase by one cycle; gate on both
  assign accept = start_i && !busy_q && (phase != PH_SEND);

  mnch_chip_timer #(
    .CHIP_CYCLES(CHIP_CYCLES)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .run_i     (phase == PH_SEND),
    .chip_end_o(chip_end)
  );

  mnch_seq #(
    .CODE_W     (CODE_W),
    .FRAME_CHIPS(FRAME_CHIPS),
    .IDX_W      (IDX_W)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .code_i    (code_i),
    .stop_i    (stop_i),
    .chip_end_i(chip_end),
    .phase_o   (phase),
    .idx_o     (idx),
    .code_o    (code_lat)
  );

  mnch_frame_enc #(
    .CODE_W     (CODE_W),
    .FRAME_CHIPS(FRAME_CHIPS),
    .IDX_W      (IDX_W)
  ) i_enc (
    .code_i(code_lat),
    .idx_i (idx),
    .chip_o(chip_bit)
  );

  // output flops keep the pin glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pin_q  <= (phase == PH_SEND) ? chip_bit : (phase == PH_WINDOW);
      busy_q <= (phase == PH_SEND);
    end
  end

  assign pin_o  = pin_q;
  assign busy_o = busy_q;

  // R2
  lead_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 (busy_o && !pin_o));

  // R8
  window_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WINDOW && !stop_i && !start_i) |=> ##1 pin_o);

  // R8
  window_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WINDOW && stop_i && !start_i) |=> ##1 !pin_o);

endmodule

// File: tb/test_mnch_marker.sv
`timescale 1ns/1ps
module test_mnch_marker;

  localparam int unsigned P = 2;
  localparam int unsigned NCH = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] code = '0;
  logic       stop = 1'b0;
  logic       pin, busy;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  mnch_marker #(.CHIP_CYCLES(P), .CODE_W(4)) i_mnch_marker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code),
    .stop_i(stop), .pin_o(pin), .busy_o(busy)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [3:0] c);
    logic [7:0] b = 8'h00;
    for (int i = 0; i < 4; i++) if (c[i]) b = b | (8'h03 << (2 * i));
    return b ^ 8'h55;
  endfunction

  function automatic logic exp_chip(input logic [3:0] c, input int j);
    logic [7:0] b = exp_byte(c);
    if (j == 0) return 1'b0;
    if (j == 1) return c[0];
    if (j == 2) return ~c[0];
    if (j < 11) return b[j-3];
    return 1'b0;
  endfunction

  // ik: cycle of interfering strobe (-1 none); use_stop picks stop vs start
  task automatic run_marker(input logic [3:0] c, input int ik, input bit use_stop,
                            input logic [3:0] oc);
    string tag;
    @(negedge clk); start = 1'b1; code = c;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    for (int k = 0; k < int'(NCH * P); k++) begin
      int j = k / P;
      if (ik >= 0 && k > ik) tag = use_stop ? "R9" : "R7";
      else if (k % P != 0) tag = "R6";
      else if (j == 0) tag = "R2";
      else if (j < 3) tag = "R3";
      else if (j < 11) tag = "R4";
      else tag = "R5";
      chk(pin, exp_chip(c, j), tag);
      chk(busy, 1'b1, "R2 busy");
      if (k == ik) begin
        if (use_stop) stop = 1'b1;
        else begin start = 1'b1; code = oc; end
      end
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
    end
    if (ik >= 0 && use_stop) begin
      chk(pin, 1'b0, "R9 pin");
      chk(busy, 1'b0, "R9 busy");
    end else begin
      chk(pin, 1'b1, "R5 window");
      chk(busy, 1'b0, "R5 busy");
    end
  endtask

  task automatic hold_window();
    for (int i = 0; i < 3; i++) begin
      chk(pin, 1'b1, "R8 hold");
      @(negedge clk);
    end
  endtask

  task automatic close_window();
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    @(negedge clk);
    chk(pin, 1'b0, "R8 close");
    chk(busy, 1'b0, "R8 busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pin, 1'b0, "R1 pin");
    chk(busy, 1'b0, "R1 busy");
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin, 1'b0, "R1 pin");
    chk(busy, 1'b0, "R1 busy");

    // sweep every code (R2..R6, R8)
    for (int c = 0; c < 16; c++) begin
      run_marker(4'(c), -1, 1'b0, 4'h0);
      hold_window();
      close_window();
    end

    // R7: start mid-marker ignored
    run_marker(4'h9, 4, 1'b0, 4'h6);
    hold_window();
    close_window();

    // R9: stop during marker suppresses the window
    run_marker(4'h3, 5, 1'b1, 4'h0);
    repeat (2) @(negedge clk);
    chk(pin, 1'b0, "R9 stays low");
    chk(busy, 1'b0, "R9 idle");

    // R10: start while window open
    run_marker(4'hC, -1, 1'b0, 4'h0);
    hold_window();
    run_marker(4'h7, -1, 1'b0, 4'h0);
    chk(pin, 1'b1, "R10 new window");
    close_window();

    // R11: stop while idle has no effect
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    @(negedge clk);
    chk(pin, 1'b0, "R11 pin");
    chk(busy, 1'b0, "R11 busy");
    run_marker(4'h2, -1, 1'b0, 4'h0);
    chk(pin, 1'b1, "R11 window opens");
    hold_window();
    close_window();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule